// File: doc/BRIEF.md
# Memory Self-Test Control Engine

This block holds the control word of a memory self-test engine and runs the test that the word describes. Software programs a seed pattern and then writes one 32-bit control word. That word selects the kind of access, how the data is formed, whether the data is complemented, which rank is tested, and whether to stop on the first error. Setting the launch bit starts a run. The engine then asks an external address sequencer for each location in turn and issues memory requests. It writes the pattern, reads it back and compares it with the expected value, or does both at each location.

The data starts at the seed for the first address. When rotation is selected, the data turns one bit to the left for every address step. A seed with a single set bit therefore walks one marker bit through the word, and with complement enabled that marker is a single 0 in a field of 1s. Hardware clears the launch bit when the run ends. It sets a sticky fail bit on any miscompare and records the first failing address and the differing bits. Software can stop a run early with an abort request, or ask for the run to halt on the first error.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset the control word reads 0, mem_req is low and mem_cs is all zeros.
- R2: A control-word write (cfg_addr 0) with bit 31 set launches a run only while idle and only if bits [26:24] are 0. With a nonzero value in [26:24], bit 31 stays 0 and no memory access occurs.
- R3: Bits [5:4] select the access. 01 is one write pass over all addresses. 10 is one read-and-compare pass. 11 writes each address and then reads it back before moving to the next. 00 completes with no memory access.
- R4: Bits [9:8] = 10 make the data equal the seed (cfg_addr 1) at the first address, rotated left by one bit per address step. Any other code uses the seed unchanged at every address.
- R5: Bit 19 set makes both written and expected data the bitwise complement of the pattern.
- R6: While a run is active, mem_cs has exactly bit N set, where N is control bits [21:20]. mem_cs is zero when idle and stays constant for the whole run.
- R7: Hardware clears bit 31 once the access for the last address (seq_last high) completes.
- R8: Bit 30 is set by any miscompare and stays set until software writes it to 0 while idle.
- R9: With bit 29 set, the run stops at the first miscompare. Bit 31 clears, bit 30 is set and no later request is issued.
- R10: A control write with bit 28 set during a run ends the run at that clock edge. No further requests are issued, bit 30 is unchanged and bit 28 reads back as 0.
- R11: cfg_addr 2 reads the first failing address and cfg_addr 3 reads the XOR of the read data and the expected data. Both read 0 once a run has launched and until its first miscompare.
- R12: While a run is active, writes to the seed and control-word writes without bit 28 have no effect.
- R13: A memory request stays asserted with stable mem_we, mem_addr and mem_wdata until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 seed, 2 fail address, 3 fail bits |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| seq_start | output | 1 | Sequencer: go to first address next cycle |
| seq_step | output | 1 | Sequencer: advance to next address next cycle |
| seq_addr | input | ADDR_W | Sequencer current address |
| seq_last | input | 1 | Sequencer: current address is the last one |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Write data |
| mem_cs | output | 4 | One-hot rank select, active during a run |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench injects a single-bit fault at one address. It checks that the fail bit rises, that the first address and the differing bits are recorded, and that the run keeps going without halt and stops with halt. A design that ignored halt would issue reads past the fault, and one that cleared capture late would show stale values from the previous run. An abort in mid-run must stop requests at once without setting the fail bit. Control and seed writes made during a run must leave the chip select and the pattern alone, and a launch with a nonzero value in bits [26:24] must be refused.

// File: rtl/mbist_pkg.sv
// Package: shared field positions, codes and state type of the memory self-test engine.
// Assumes a 32-bit control word whose bit layout software depends on.
package mbist_pkg;
    localparam int CW       = 32;
    localparam int B_START  = 31;
    localparam int B_FAIL   = 30;
    localparam int B_HALT   = 29;
    localparam int B_ABORT  = 28;
    localparam int ALGO_LO  = 24;
    localparam int ALGO_W   = 3;
    localparam int RANK_LO  = 20;
    localparam int RANK_W   = 2;
    localparam int B_INV    = 19;
    localparam int DT_LO    = 8;
    localparam int CMD_LO   = 4;

    localparam logic [1:0] CMD_NONE = 2'b00;
    localparam logic [1:0] CMD_WR   = 2'b01;
    localparam logic [1:0] CMD_RD   = 2'b10;
    localparam logic [1:0] CMD_WRRD = 2'b11;
    localparam logic [1:0] DT_ROT   = 2'b10;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_SEED = 2'd1;
    localparam logic [1:0] SEL_FADR = 2'd2;
    localparam logic [1:0] SEL_FBIT = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ARM, ST_WR, ST_RD, ST_NEXT, ST_DONE
    } eng_state_t;
endpackage

// File: rtl/mbist_regs.sv
// Module: mbist_regs
// Holds the control word, the seed and the miscompare capture registers.
// Decodes launch and abort requests. While a run is active it accepts only aborts.
// Assumes DATA_W and ADDR_W are no wider than the 32-bit register port.
module mbist_regs
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_addr,
    input  logic [CW-1:0]     cfg_wdata,
    output logic [CW-1:0]     cfg_rdata,
    input  logic              run_done,
    input  logic              run_miscmp,
    input  logic [ADDR_W-1:0] miscmp_addr,
    input  logic [DATA_W-1:0] miscmp_diff,
    output logic              launch,
    output logic              abort_req,
    output logic              busy,
    output logic [1:0]        cmd,
    output logic [1:0]        dtype,
    output logic              invert,
    output logic [RANK_W-1:0] rank,
    output logic              halt,
    output logic [DATA_W-1:0] seed
);
    logic              start_q, fail_q, halt_q, inv_q, cap_taken_q;
    logic [ALGO_W-1:0] algo_q;
    logic [RANK_W-1:0] rank_q;
    logic [1:0]        dt_q, cmd_q;
    logic [DATA_W-1:0] seed_q, cap_diff_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic              ctrl_wr, idle_ctrl_wr;
    logic              unused_wbits;

    assign ctrl_wr      = cfg_wr && (cfg_addr == SEL_CTRL);
    assign idle_ctrl_wr = ctrl_wr && !start_q;
    assign launch       = idle_ctrl_wr && cfg_wdata[B_START]
                          && (cfg_wdata[ALGO_LO +: ALGO_W] == '0);
    assign abort_req    = ctrl_wr && start_q && cfg_wdata[B_ABORT];
    assign unused_wbits = ^cfg_wdata;

    // Software-owned fields: loaded only by a control write while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            dt_q   <= '0;
            inv_q  <= 1'b0;
            rank_q <= '0;
            halt_q <= 1'b0;
            algo_q <= '0;
        end else if (idle_ctrl_wr) begin
            cmd_q  <= cfg_wdata[CMD_LO +: 2];
            dt_q   <= cfg_wdata[DT_LO +: 2];
            inv_q  <= cfg_wdata[B_INV];
            rank_q <= cfg_wdata[RANK_LO +: RANK_W];
            halt_q <= cfg_wdata[B_HALT];
            algo_q <= cfg_wdata[ALGO_LO +: ALGO_W];
        end
    end

    // Start bit: set by a valid launch, cleared by completion or abort.
    always_ff @(posedge clk) begin
        if (!rst_n)                      start_q <= 1'b0;
        else if (launch)                 start_q <= 1'b1;
        else if (abort_req || run_done)  start_q <= 1'b0;
    end

    // Fail bit: set by any miscompare, otherwise written by software while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            fail_q <= 1'b0;
        else if (run_miscmp)   fail_q <= 1'b1;
        else if (idle_ctrl_wr) fail_q <= cfg_wdata[B_FAIL];
    end

    // Seed register: writable only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                            seed_q <= '0;
        else if (cfg_wr && cfg_addr == SEL_SEED && !start_q)   seed_q <= cfg_wdata[DATA_W-1:0];
    end

    // Capture of the first miscompare of a run; cleared at launch.
    always_ff @(posedge clk) begin
        if (!rst_n || launch) begin
            cap_addr_q  <= '0;
            cap_diff_q  <= '0;
            cap_taken_q <= 1'b0;
        end else if (run_miscmp && !cap_taken_q) begin
            cap_addr_q  <= miscmp_addr;
            cap_diff_q  <= miscmp_diff;
            cap_taken_q <= 1'b1;
        end
    end

    // Read mux: control word carries hardware status; abort always reads 0.
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_addr)
            SEL_CTRL: begin
                cfg_rdata[B_START]              = start_q;
                cfg_rdata[B_FAIL]               = fail_q;
                cfg_rdata[B_HALT]               = halt_q;
                cfg_rdata[ALGO_LO +: ALGO_W]    = algo_q;
                cfg_rdata[RANK_LO +: RANK_W]    = rank_q;
                cfg_rdata[B_INV]                = inv_q;
                cfg_rdata[DT_LO +: 2]           = dt_q;
                cfg_rdata[CMD_LO +: 2]          = cmd_q;
            end
            SEL_SEED: cfg_rdata = CW'(seed_q);
            SEL_FADR: cfg_rdata = CW'(cap_addr_q);
            default:  cfg_rdata = CW'(cap_diff_q);
        endcase
    end

    assign busy   = start_q;
    assign cmd    = cmd_q;
    assign dtype  = dt_q;
    assign invert = inv_q;
    assign rank   = rank_q;
    assign halt   = halt_q;
    assign seed   = seed_q;

    AST_LAUNCH_NEEDS_ALGO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> $past(ctrl_wr && cfg_wdata[ALGO_LO +: ALGO_W] == '0)); // R2
    AST_DONE_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        run_done |=> !start_q); // R7
    AST_FAIL_SW_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fail_q) |-> $past(ctrl_wr && !start_q)); // R8
    AST_ABORT_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !start_q); // R10
endmodule

// File: rtl/mbist_pattern.sv
// Module: mbist_pattern
// Test data generator: loads the seed for the first address and optionally rotates
// it left one bit per address step. The output is complemented when invert is set.
// Assumes load and step are never asserted together.
module mbist_pattern #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              rotate,
    input  logic              invert,
    input  logic [DATA_W-1:0] seed,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] pat_q;

    // Pattern register: seed on load, left rotation on a step when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)               pat_q <= '0;
        else if (load)            pat_q <= seed;
        else if (step && rotate)  pat_q <= {pat_q[DATA_W-2:0], pat_q[DATA_W-1]};
    end

    assign data = invert ? ~pat_q : pat_q;

    AST_ROTATE_KEEPS_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        step && rotate && !load |=> $countones(pat_q) == $countones($past(pat_q))); // R4
endmodule

// File: rtl/mbist_fsm.sv
// Module: mbist_fsm
// Sequencing state machine: restarts the address sequencer, issues write and/or read
// requests per address, flags miscompares, and ends on the last address, on halt or on abort.
// Assumes the sequencer presents a new address the cycle after seq_start or seq_step.
module mbist_fsm
    import mbist_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    input  logic       abort_req,
    input  logic [1:0] cmd,
    input  logic       halt,
    input  logic       seq_last,
    input  logic       mem_ack,
    input  logic       mismatch,
    output logic       seq_start,
    output logic       seq_step,
    output logic       mem_req,
    output logic       mem_we,
    output logic       pat_load,
    output logic       pat_step,
    output logic       run_done,
    output logic       run_miscmp
);
    eng_state_t state_q, state_d;
    eng_state_t first_op;

    assign first_op = cmd[0] ? ST_WR : ST_RD;

    // Next-state logic for the per-address access sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_ARM;
            ST_ARM:  state_d = (cmd == CMD_NONE) ? ST_DONE : first_op;
            ST_WR:   if (mem_ack) state_d = (cmd == CMD_WRRD) ? ST_RD : ST_NEXT;
            ST_RD:   if (mem_ack) state_d = (mismatch && halt) ? ST_DONE : ST_NEXT;
            ST_NEXT: state_d = seq_last ? ST_DONE : first_op;
            default: state_d = ST_IDLE;
        endcase
        if (abort_req) state_d = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign seq_start  = (state_q == ST_ARM);
    assign pat_load   = (state_q == ST_ARM);
    assign seq_step   = (state_q == ST_NEXT) && !seq_last && !abort_req;
    assign pat_step   = seq_step;
    assign mem_req    = ((state_q == ST_WR) || (state_q == ST_RD)) && !abort_req;
    assign mem_we     = (state_q == ST_WR);
    assign run_done   = (state_q == ST_DONE);
    assign run_miscmp = (state_q == ST_RD) && mem_ack && mismatch && !abort_req;

    AST_HALT_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_miscmp && halt |=> state_q == ST_DONE); // R9
    AST_NO_REQ_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> !mem_req); // R10
endmodule

// File: rtl/mbist_ctrl.sv
// Module: mbist_ctrl (top)
// Memory self-test control engine: register block, pattern generator and sequencing
// state machine, plus the data compare and rank chip-select decode.
// Assumes an external address sequencer and a request/acknowledge memory port.
module mbist_ctrl
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [1:0]            cfg_addr,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    output logic                  seq_start,
    output logic                  seq_step,
    input  logic [ADDR_W-1:0]     seq_addr,
    input  logic                  seq_last,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [3:0]            mem_cs,
    input  logic                  mem_ack,
    input  logic [DATA_W-1:0]     mem_rdata
);
    localparam int NUM_CS = 1 << RANK_W;

    logic              launch, abort_req, busy, invert, halt;
    logic              run_done, run_miscmp, pat_load, pat_step, mismatch;
    logic [1:0]        cmd, dtype;
    logic [RANK_W-1:0] rank;
    logic [DATA_W-1:0] seed, pat_data, diff;

    mbist_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .run_done, .run_miscmp, .miscmp_addr(seq_addr), .miscmp_diff(diff),
        .launch, .abort_req, .busy, .cmd, .dtype, .invert, .rank, .halt, .seed
    );

    mbist_pattern #(.DATA_W(DATA_W)) u_pat (
        .clk, .rst_n, .load(pat_load), .step(pat_step),
        .rotate(dtype == DT_ROT), .invert, .seed, .data(pat_data)
    );

    mbist_fsm u_fsm (
        .clk, .rst_n, .launch, .abort_req, .cmd, .halt, .seq_last, .mem_ack,
        .mismatch, .seq_start, .seq_step, .mem_req, .mem_we,
        .pat_load, .pat_step, .run_done, .run_miscmp
    );

    assign diff      = mem_rdata ^ pat_data;
    assign mismatch  = |diff;
    assign mem_addr  = seq_addr;
    assign mem_wdata = pat_data;

    // One chip-select line per rank, driven only while a run is active.
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign mem_cs[i] = busy && (rank == RANK_W'(i));
    end

    AST_CS_STABLE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mem_cs)); // R6
    AST_REQ_HELD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack && !abort_req |=> mem_req && $stable(mem_we)
            && $stable(mem_addr) && $stable(mem_wdata)); // R13
endmodule

// File: tb/mbist_ctrl_tb.sv
// Bench: directed tests against an 8-location sequencer and a behavioural memory
// that acknowledges every request one cycle after it is raised.
module mbist_ctrl_tb;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int LAST   = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_addr = 2'd0;
    logic [31:0]       cfg_wdata = '0;
    logic [31:0]       cfg_rdata;
    logic              seq_start, seq_step, seq_last;
    logic [ADDR_W-1:0] seq_addr;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [3:0]        mem_cs;

    logic              fault_en = 1'b0;
    logic [ADDR_W-1:0] fault_addr = '0;
    logic [31:0]       fault_mask = '0;
    logic              mon_off = 1'b0;
    logic              timed_out = 1'b0;

    logic [31:0] mem [0:15];
    logic [4:0]  op_log [0:255];
    int          op_cnt = 0, wr_cnt = 0, rd_cnt = 0, hold_err = 0;
    int          errors = 0, checks = 0;
    logic        prev_pend = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [DATA_W-1:0] prev_wdata = '0;

    always #5 clk = ~clk;

    mbist_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .seq_start, .seq_step, .seq_addr, .seq_last,
        .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_cs, .mem_ack, .mem_rdata
    );

    // Address sequencer model.
    always @(posedge clk) begin
        if (!rst_n)         seq_addr <= '0;
        else if (seq_start) seq_addr <= '0;
        else if (seq_step)  seq_addr <= seq_addr + 1'b1;
    end
    assign seq_last = (seq_addr == ADDR_W'(LAST));

    // Memory model, access log and request-hold monitor.
    always @(posedge clk) begin
        if (!rst_n) mem_ack <= 1'b0;
        else        mem_ack <= mem_req && !mem_ack;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[3:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
            op_log[op_cnt % 256] <= {mem_we, mem_addr[3:0]};
            op_cnt <= op_cnt + 1;
        end
        if (prev_pend && !mon_off &&
            (!mem_req || mem_addr != prev_addr || mem_wdata != prev_wdata))
            hold_err <= hold_err + 1;
        prev_pend  <= mem_req && !mem_ack;
        prev_addr  <= mem_addr;
        prev_wdata <= mem_wdata;
    end
    assign mem_rdata = mem[mem_addr[3:0]] ^
                       ((fault_en && mem_addr == fault_addr) ? fault_mask : 32'h0);

    function automatic logic [31:0] rotl(input logic [31:0] v, input int n);
        return (n % 32 == 0) ? v : ((v << (n % 32)) | (v >> (32 - n % 32)));
    endfunction

    function automatic logic [31:0] mk(input logic st, input logic hl, input logic fl,
                                       input logic [1:0] rk, input logic iv,
                                       input logic [1:0] dt, input logic [1:0] cm,
                                       input logic [2:0] al);
        logic [31:0] w;
        w = '0;
        w[31] = st; w[30] = fl; w[29] = hl; w[26:24] = al;
        w[21:20] = rk; w[19] = iv; w[9:8] = dt; w[5:4] = cm;
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            cfg_read(2'd0, d);
            if (!d[31]) break;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        cfg_read(2'd0, d);
        check(d == 0, "R1 ctrl after reset", d, 0);
        check(!mem_req && mem_cs == 0, "R1 idle outputs", {mem_req, mem_cs}, 0);
    endtask

    task automatic t_algo_refused();
        logic [31:0] d;
        int w0 = op_cnt;
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b10, 2'b01, 3'd1));
        repeat (10) @(negedge clk);
        cfg_read(2'd0, d);
        check(!d[31], "R2 start refused with nonzero [26:24]", d[31], 0);
        check(op_cnt == w0, "R2 no access when refused", op_cnt - w0, 0);
    endtask

    task automatic t_walk_zero_write();
        logic [31:0] d;
        int w0 = wr_cnt, r0 = rd_cnt;
        cfg_write(2'd1, 32'h0000_0001);
        cfg_write(2'd0, mk(1, 0, 0, 2'd2, 1, 2'b10, 2'b01, 3'd0));
        check(mem_cs == 4'b0100, "R6 chip select during run", mem_cs, 4'b0100);
        wait_done();
        cfg_read(2'd0, d);
        check(!d[31], "R7 start cleared at end", d[31], 0);
        check(mem_cs == 0, "R6 chip select idle", mem_cs, 0);
        check(wr_cnt - w0 == 8 && rd_cnt == r0, "R3 write pass counts", wr_cnt - w0, 8);
        for (int i = 0; i <= LAST; i++)
            check(mem[i] == ~rotl(32'h1, i), "R4 R5 walking zero", mem[i], ~rotl(32'h1, i));
    endtask

    task automatic t_read_pass();
        logic [31:0] d;
        int w0 = wr_cnt, r0 = rd_cnt;
        cfg_write(2'd0, mk(1, 0, 0, 2'd1, 1, 2'b10, 2'b10, 3'd0));
        wait_done();
        cfg_read(2'd0, d);
        check(!d[30], "R3 read pass of good data passes", d[30], 0);
        check(rd_cnt - r0 == 8 && wr_cnt == w0, "R3 read pass counts", rd_cnt - r0, 8);
    endtask

    task automatic t_fixed_seed();
        cfg_write(2'd1, 32'h0000_00A5);
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b00, 2'b01, 3'd0));
        wait_done();
        for (int i = 0; i <= LAST; i += 3)
            check(mem[i] == 32'hA5, "R4 fixed seed without rotation", mem[i], 32'hA5);
    endtask

    task automatic t_fault_no_halt();
        logic [31:0] d;
        int b = op_cnt, r0 = rd_cnt;
        cfg_write(2'd1, 32'h0000_0001);
        fault_en = 1'b1; fault_addr = 16'd5; fault_mask = 32'h8;
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b10, 2'b11, 3'd0));
        wait_done();
        fault_en = 1'b0;
        check(op_log[b % 256] == 5'h10 && op_log[(b + 1) % 256] == 5'h00 &&
              op_log[(b + 2) % 256] == 5'h11, "R3 write then read per address",
              {op_log[b % 256], op_log[(b + 1) % 256], op_log[(b + 2) % 256]}, 15'h4011);
        check(rd_cnt - r0 == 8, "R9 no halt continues", rd_cnt - r0, 8);
        cfg_read(2'd0, d);
        check(d[30], "R8 fail set on miscompare", d[30], 1);
        cfg_read(2'd2, d);
        check(d == 5, "R11 first fail address", d, 5);
        cfg_read(2'd3, d);
        check(d == 8, "R11 fail bits", d, 8);
    endtask

    task automatic t_clear_and_ignore();
        logic [31:0] d;
        cfg_write(2'd0, 32'h0);
        cfg_read(2'd0, d);
        check(!d[30], "R8 software clears fail", d[30], 0);
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b10, 2'b01, 3'd0));
        cfg_read(2'd2, d);
        check(d == 0, "R11 fail address cleared at launch", d, 0);
        cfg_read(2'd3, d);
        check(d == 0, "R11 fail bits cleared at launch", d, 0);
        cfg_write(2'd0, mk(1, 0, 0, 2'd3, 1, 2'b00, 2'b10, 3'd0));
        cfg_write(2'd1, 32'hFFFF_0000);
        check(mem_cs == 4'b0001, "R12 rank unchanged by busy write", mem_cs, 4'b0001);
        cfg_read(2'd1, d);
        check(d == 1, "R12 seed unchanged by busy write", d, 1);
        wait_done();
        check(mem[6] == rotl(32'h1, 6), "R12 run used original config", mem[6], rotl(32'h1, 6));
    endtask

    task automatic t_halt();
        logic [31:0] d;
        int r0 = rd_cnt;
        fault_en = 1'b1; fault_addr = 16'd3; fault_mask = 32'h100;
        cfg_write(2'd0, mk(1, 1, 0, 0, 0, 2'b10, 2'b11, 3'd0));
        wait_done();
        repeat (10) @(negedge clk);
        fault_en = 1'b0;
        check(rd_cnt - r0 == 4, "R9 halt stops at first miscompare", rd_cnt - r0, 4);
        cfg_read(2'd0, d);
        check(d[30] && !d[31], "R9 halt status", d[31:30], 2'b01);
        cfg_read(2'd2, d);
        check(d == 3, "R9 R11 halt fail address", d, 3);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        int w0, w1;
        cfg_write(2'd0, 32'h0);
        w0 = wr_cnt;
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b10, 2'b01, 3'd0));
        repeat (5) @(negedge clk);
        mon_off = 1'b1;
        cfg_write(2'd0, 32'h1000_0000);
        check(!mem_req, "R10 no request after abort", mem_req, 0);
        w1 = wr_cnt;
        repeat (20) @(negedge clk);
        mon_off = 1'b0;
        cfg_read(2'd0, d);
        check(!d[31] && !d[30] && !d[28], "R10 abort status", d[31:28], 0);
        check(wr_cnt == w1 && (w1 - w0) < 8, "R10 run cut short", w1 - w0, 8);
    endtask

    task automatic t_cmd_none();
        logic [31:0] d;
        int o0 = op_cnt;
        cfg_write(2'd0, mk(1, 0, 0, 0, 0, 2'b10, 2'b00, 3'd0));
        wait_done();
        cfg_read(2'd0, d);
        check(!d[31] && op_cnt == o0, "R3 command 00 completes with no access",
              op_cnt - o0, 0);
    endtask

    task automatic run_all();
        t_reset();
        t_algo_refused();
        t_walk_zero_write();
        t_read_pass();
        t_fixed_seed();
        t_fault_no_halt();
        t_clear_and_ignore();
        t_halt();
        t_abort();
        t_cmd_none();
        check(hold_err == 0, "R13 request held until ack", hold_err, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule